// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter with Drift Trim

This block keeps wall-clock time and a calendar in packed BCD registers: seconds, minutes, hours, day of month, month, two-digit year and day of week. A prescaler divides the block clock down to one tick per second, and the calendar fields advance on that tick with full carry through to the year. A host reaches every field and a control register through one byte-wide port, writing with a single-cycle strobe and reading through a combinational data path.

The control register has two flags. The first stops all counting so that the host can load a new time. The second freezes the values the host sees, so that a multi-byte read is coherent while the counters keep running underneath. The low six bits of the same register hold a sign-and-magnitude trim. Once in every correction period, the trim lengthens or shortens one second by a scaled number of prescaler counts, and a positive step weighs twice a negative one.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset, control reads 0x00, seconds, minutes, hours and year read 0x00, and date, month and day of week read 0x01.
- R2: With zero trim, seconds advance by one BCD step every PRESCALE clock cycles, and 0x59 wraps to 0x00 with a carry into minutes.
- R3: Minutes wrap 0x59 to 0x00 with a carry into hours, and hours wrap 0x23 to 0x00 with a carry into the date.
- R4: The date wraps to 0x01 after the last day of the month (0x30 for months 04, 06, 09, 0x11; 0x31 for the other months except 02). February ends at 0x29 when the two-digit year is divisible by 4 and at 0x28 otherwise. Month runs 0x01 to 0x12 and wraps to 0x01.
- R5: The year advances on a wrap from December to January and goes from 0x99 to 0x00.
- R6: While the hold bit (control bit 7) is set, no field advances. Writes to the time fields (addresses 1 to 7: sec, min, hour, date, month, year, dow) take effect only while hold is set and are otherwise ignored.
- R7: A time-field write clears the prescaler, so that after hold is released the seconds field changes exactly PRESCALE cycles after the releasing write.
- R8: Control bits 7 (hold) and 6 (freeze) can always be written. Trim bits [4:0] (magnitude) and bit 5 (negative sign) change only on a control write made while hold is already set. The control register reads back at address 0.
- R9: In every window of CORR_SECS consecutive seconds, exactly one second is lengthened by magnitude*POS_STEP cycles when the sign is clear, or shortened by magnitude*NEG_STEP cycles when it is set. A magnitude of zero applies no correction.
- R10: While the freeze bit is set, reads of the time fields return the values captured when it was set, and counting goes on underneath. When the bit clears, reads show the live values again.
- R11: Day of week advances on every date change and wraps from 0x07 to 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, also the prescaler source |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| addr_i | input | 3 | Register select: 0 control, 1..7 time fields |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i (combinational) |

## Verification
Random valid times are loaded, with each field biased toward its maximum, so that a single second exercises carries at every depth: none, into minutes, into the date, across month ends in leap and non-leap years, and across the year wrap. Each result is compared with a bench calendar model, which distinguishes wrong rollover limits from wrong carry gating. Directed runs measure the total length of a correction period under positive, negative and zero trim, which separates the two step weights and the sign handling. Further directed runs test hold, ignored writes, locked trim, read freeze against live counting, and the exact cycle of the first second after a load.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] sec;
    logic [7:0] min;
    logic [7:0] hour;
    logic [7:0] date;
    logic [7:0] mon;
    logic [7:0] year;
    logic [7:0] dow;
  } rtc_time_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_SEC  = 3'd1;
  localparam logic [2:0] A_MIN  = 3'd2;
  localparam logic [2:0] A_HOUR = 3'd3;
  localparam logic [2:0] A_DATE = 3'd4;
  localparam logic [2:0] A_MON  = 3'd5;
  localparam logic [2:0] A_YEAR = 3'd6;
  localparam logic [2:0] A_DOW  = 3'd7;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // 10*t + u mod 4 equals 2*t + u mod 4
  function automatic logic leap_bcd(input logic [7:0] yr);
    logic [3:0] s;
    s = {yr[6:4], 1'b0} + yr[3:0];
    return s[1:0] == 2'd0;
  endfunction

  function automatic logic [7:0] last_day_bcd(input logic [7:0] mon, input logic [7:0] yr);
    case (mon)
      8'h02: return leap_bcd(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default: return 8'h31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESCALE  = 100,
  parameter int POS_STEP  = 2,
  parameter int NEG_STEP  = 1,
  parameter int CORR_SECS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       clr_i,
  input  logic [4:0] trim_mag_i,
  input  logic       trim_neg_i,
  output logic       tick_o
);
  localparam int MAX_TERM = PRESCALE - 1 + 31 * POS_STEP;
  localparam int CNT_W    = $clog2(MAX_TERM + 1);
  localparam int PER_W    = (CORR_SECS > 1) ? $clog2(CORR_SECS) : 1;

  logic [CNT_W-1:0] cnt_q, term;
  logic [PER_W-1:0] per_q;

  always_comb begin
    term = CNT_W'(PRESCALE - 1);
    if (per_q == '0 && trim_mag_i != 5'd0) begin
      if (trim_neg_i) term = CNT_W'(PRESCALE - 1) - CNT_W'(int'(trim_mag_i) * NEG_STEP);
      else            term = CNT_W'(PRESCALE - 1) + CNT_W'(int'(trim_mag_i) * POS_STEP);
    end
  end

  // >= so a count left past a shortened terminal still ends the second
  assign tick_o = en_i && (cnt_q >= term);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      per_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (tick_o) begin
      cnt_q <= '0;
      per_q <= (per_q == PER_W'(CORR_SECS - 1)) ? '0 : per_q + PER_W'(1);
    end else if (en_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       we_i,
  input  logic [2:0] sel_i,
  input  logic [7:0] data_i,
  output rtc_time_t  time_o
);
  rtc_time_t t_q;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    c_min  = t_q.sec == 8'h59;
    c_hour = c_min && t_q.min == 8'h59;
    c_day  = c_hour && t_q.hour == 8'h23;
    c_mon  = c_day && t_q.date == last_day_bcd(t_q.mon, t_q.year);
    c_year = c_mon && t_q.mon == 8'h12;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, date: 8'h01,
               mon: 8'h01, year: 8'h00, dow: 8'h01};
    end else if (we_i) begin
      case (sel_i)
        A_SEC:   t_q.sec  <= data_i;
        A_MIN:   t_q.min  <= data_i;
        A_HOUR:  t_q.hour <= data_i;
        A_DATE:  t_q.date <= data_i;
        A_MON:   t_q.mon  <= data_i;
        A_YEAR:  t_q.year <= data_i;
        A_DOW:   t_q.dow  <= data_i;
        default: ;
      endcase
    end else if (tick_i) begin
      t_q.sec <= c_min ? 8'h00 : bcd_inc(t_q.sec);
      if (c_min)  t_q.min  <= c_hour ? 8'h00 : bcd_inc(t_q.min);
      if (c_hour) t_q.hour <= c_day ? 8'h00 : bcd_inc(t_q.hour);
      if (c_day) begin
        t_q.date <= c_mon ? 8'h01 : bcd_inc(t_q.date);
        t_q.dow  <= (t_q.dow == 8'h07) ? 8'h01 : bcd_inc(t_q.dow);
      end
      if (c_mon)  t_q.mon  <= c_year ? 8'h01 : bcd_inc(t_q.mon);
      if (c_year) t_q.year <= (t_q.year == 8'h99) ? 8'h00 : bcd_inc(t_q.year);
    end
  end

  assign time_o = t_q;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE  = 100,
  parameter int POS_STEP  = 2,
  parameter int NEG_STEP  = 1,
  parameter int CORR_SECS = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [2:0] addr_i,
  input  logic [7:0] wr_data_i,
  output logic [7:0] rd_data_o
);
  logic       hold_q, freeze_q, trim_neg_q;
  logic [4:0] trim_mag_q;
  logic       ctrl_we, field_we, tick;
  rtc_time_t  live, snap_q, view;

  assign ctrl_we  = wr_en_i && addr_i == A_CTRL;
  assign field_we = wr_en_i && addr_i != A_CTRL && hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      freeze_q   <= 1'b0;
      trim_neg_q <= 1'b0;
      trim_mag_q <= '0;
    end else if (ctrl_we) begin
      hold_q   <= wr_data_i[7];
      freeze_q <= wr_data_i[6];
      if (hold_q) begin
        trim_neg_q <= wr_data_i[5];
        trim_mag_q <= wr_data_i[4:0];
      end
    end
  end

  rtc_prescaler #(
    .PRESCALE(PRESCALE), .POS_STEP(POS_STEP),
    .NEG_STEP(NEG_STEP), .CORR_SECS(CORR_SECS)
  ) u_pre (
    .clk_i, .rst_ni,
    .en_i(!hold_q), .clr_i(field_we),
    .trim_mag_i(trim_mag_q), .trim_neg_i(trim_neg_q),
    .tick_o(tick)
  );

  rtc_calendar u_cal (
    .clk_i, .rst_ni,
    .tick_i(tick), .we_i(field_we), .sel_i(addr_i), .data_i(wr_data_i),
    .time_o(live)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (!freeze_q) snap_q <= live;
  end

  assign view = freeze_q ? snap_q : live;

  always_comb begin
    case (addr_i)
      A_SEC:   rd_data_o = view.sec;
      A_MIN:   rd_data_o = view.min;
      A_HOUR:  rd_data_o = view.hour;
      A_DATE:  rd_data_o = view.date;
      A_MON:   rd_data_o = view.mon;
      A_YEAR:  rd_data_o = view.year;
      A_DOW:   rd_data_o = view.dow;
      default: rd_data_o = {hold_q, freeze_q, trim_neg_q, trim_mag_q};
    endcase
  end
endmodule

// File: rtl/rtc_bcd_chk.sv
module rtc_bcd_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hold_i,
  input logic       freeze_i,
  input logic       tick_i,
  input logic       wr_field_i,
  input logic [7:0] sec_i,
  input logic [7:0] snap_sec_i,
  input logic [5:0] trim_i
);
  assert_hold_no_tick_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !tick_i);

  assert_hold_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !wr_field_i |=> $stable(sec_i));

  assert_sec_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && sec_i == 8'h59 |=> sec_i == 8'h00);

  assert_trim_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_i |=> $stable(trim_i));

  assert_freeze_snap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze_i |=> !freeze_i || $stable(snap_sec_i));
endmodule

bind rtc_bcd_core rtc_bcd_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_q), .freeze_i(freeze_q),
  .tick_i(tick), .wr_field_i(field_we), .sec_i(live.sec), .snap_sec_i(snap_q.sec),
  .trim_i({trim_neg_q, trim_mag_q})
);

// File: tb/sim_rtc_bcd_core.sv
module sim_rtc_bcd_core;
  localparam int CLK_PERIOD = 10;
  localparam int PRESCALE   = 100;
  localparam int POS_STEP   = 2;
  localparam int NEG_STEP   = 1;
  localparam int CORR_SECS  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_core #(.PRESCALE(PRESCALE), .POS_STEP(POS_STEP),
                 .NEG_STEP(NEG_STEP), .CORR_SECS(CORR_SECS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .addr_i(addr), .wr_data_i(wdata), .rd_data_o(rdata));

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  // t: sec,min,hour,date,mon,year,dow in binary
  function automatic void next_sec(ref int t[7]);
    t[0]++;
    if (t[0] < 60) return;
    t[0] = 0; t[1]++;
    if (t[1] < 60) return;
    t[1] = 0; t[2]++;
    if (t[2] < 24) return;
    t[2] = 0;
    t[6] = (t[6] == 7) ? 1 : t[6] + 1;
    t[3]++;
    if (t[3] <= dim(t[4], t[5])) return;
    t[3] = 1; t[4]++;
    if (t[4] <= 12) return;
    t[4] = 1; t[5] = (t[5] + 1) % 100;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic load(input int t[7]);
    wr(3'd0, 8'h80);
    for (int i = 0; i < 7; i++) wr(3'(i + 1), to_bcd(t[i]));
  endtask

  // sum of CORR_SECS consecutive second lengths
  task automatic measure(output int total);
    logic [7:0] prev, cur;
    int guard;
    total = 0;
    @(negedge clk);
    rd(3'd1, prev);
    guard = 0;
    do begin
      @(negedge clk); rd(3'd1, cur); guard++;
    end while (cur == prev && guard < 1000);
    prev = cur;
    for (int k = 0; k < CORR_SECS; k++) begin
      int c;
      c = 0;
      do begin
        @(negedge clk); rd(3'd1, cur); c++;
      end while (cur == prev && c < 1000);
      prev = cur;
      total += c;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int t[7];
    int tot;
    void'($urandom(32'd20240427));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd1, v); chk("R1 sec", v, 8'h00);
    rd(3'd2, v); chk("R1 min", v, 8'h00);
    rd(3'd3, v); chk("R1 hour", v, 8'h00);
    rd(3'd4, v); chk("R1 date", v, 8'h01);
    rd(3'd5, v); chk("R1 mon", v, 8'h01);
    rd(3'd6, v); chk("R1 year", v, 8'h00);
    rd(3'd7, v); chk("R1 dow", v, 8'h01);

    // R2..R5, R11: random loads biased to rollovers, one second forward
    for (int it = 0; it < 40; it++) begin
      logic [7:0] exp_b;
      t[0] = ($urandom % 2) ? 59 : $urandom % 60;
      t[1] = ($urandom % 2) ? 59 : $urandom % 60;
      t[2] = ($urandom % 2) ? 23 : $urandom % 24;
      t[4] = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
      t[5] = ($urandom % 4 == 0) ? 99 : $urandom % 100;
      t[3] = ($urandom % 2) ? dim(t[4], t[5]) : 1 + $urandom % dim(t[4], t[5]);
      t[6] = 1 + $urandom % 7;
      if (it == 0) begin t = '{59, 59, 23, 28, 2, 24, 7}; end
      if (it == 1) begin t = '{59, 59, 23, 28, 2, 23, 3}; end
      if (it == 2) begin t = '{59, 59, 23, 31, 12, 99, 5}; end
      if (it == 3) begin t = '{59, 59, 23, 30, 4, 10, 2}; end
      load(t);
      wr(3'd0, 8'h00);
      repeat (100) @(negedge clk);
      next_sec(t);
      rd(3'd1, v); chk("R2 sec", v, to_bcd(t[0]));
      rd(3'd2, v); chk("R3 min", v, to_bcd(t[1]));
      rd(3'd3, v); chk("R3 hour", v, to_bcd(t[2]));
      rd(3'd4, v); chk("R4 date", v, to_bcd(t[3]));
      rd(3'd5, v); chk("R4 mon", v, to_bcd(t[4]));
      rd(3'd6, v); exp_b = to_bcd(t[5]); chk("R5 year", v, exp_b);
      rd(3'd7, v); chk("R11 dow", v, to_bcd(t[6]));
    end

    // R7 exact cycle of first second after load
    t = '{20, 0, 0, 1, 1, 0, 1};
    load(t);
    wr(3'd0, 8'h00);
    repeat (99) @(negedge clk);
    rd(3'd1, v); chk("R7 before", v, 8'h20);
    @(negedge clk);
    rd(3'd1, v); chk("R7 at PRESCALE", v, 8'h21);

    // R6 hold stops counting; writes without hold ignored
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h10);
    repeat (300) @(negedge clk);
    rd(3'd1, v); chk("R6 held", v, 8'h10);
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h30);
    rd(3'd1, v); chk("R6 ignored write", v, 8'h10);
    wr(3'd3, 8'h05);
    rd(3'd3, v); chk("R6 ignored hour", v, 8'h00);

    // R10 freeze
    t = '{10, 0, 0, 1, 1, 0, 1};
    load(t);
    wr(3'd0, 8'h00);
    repeat (50) @(negedge clk);
    wr(3'd0, 8'h40);
    repeat (200) @(negedge clk);
    rd(3'd1, v); chk("R10 frozen", v, 8'h10);
    rd(3'd0, v); chk("R8 ctrl freeze", v, 8'h40);
    wr(3'd0, 8'h00);
    rd(3'd1, v); chk("R10 live", v, 8'h12);

    // R8 trim lock
    wr(3'd0, 8'h85);
    rd(3'd0, v); chk("R8 trim locked on entry", v, 8'h80);
    wr(3'd0, 8'h85);
    rd(3'd0, v); chk("R8 trim set", v, 8'h85);
    wr(3'd0, 8'h05);
    wr(3'd0, 8'h0A);
    rd(3'd0, v); chk("R8 trim no hold", v, 8'h05);

    // R9 positive, negative, zero trim
    measure(tot);
    chk_int("R9 positive", tot, CORR_SECS * PRESCALE + 5 * POS_STEP);
    wr(3'd0, 8'h80);
    wr(3'd0, 8'hA7);
    wr(3'd0, 8'h27);
    measure(tot);
    chk_int("R9 negative", tot, CORR_SECS * PRESCALE - 7 * NEG_STEP);
    wr(3'd0, 8'h80);
    wr(3'd0, 8'hA0);
    wr(3'd0, 8'h20);
    measure(tot);
    chk_int("R9 zero", tot, CORR_SECS * PRESCALE);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule